// File: doc/BRIEF.md
# Credit-Aware Switch Allocator for a Virtual-Channel Wormhole Router

This block decides, in every clock cycle, which buffered flits cross the crossbar of a router with `NPORT` physical ports and `NVC` virtual channels per port. Flits of every kind (head, body, tail) compete in the same way. No flit-type input exists. An input VC is eligible when three things hold: it holds a flit, it has already been given an output port and output VC by the VC allocation stage, and that downstream VC still has buffer space.

Arbitration runs in two separable levels. A round-robin arbiter in each input port picks one eligible VC. A round-robin arbiter in each output port then picks one of the input ports whose winners target it. An input port whose first-level winner loses at the second level sends nothing, and its first-level pointer stays where it was. The grants are combinational in the cycle of the request. The block also holds one credit counter per downstream VC. A counter drops when a flit leaves toward that VC and rises when the downstream router frees a slot. The allocated output VC number that leaves with each flit is driven as the flit's new VC tag.

Top module: `swa_switch_alloc`

## Requirements
- R1: An input VC requests only if `in_valid` is high, its `in_oport` field holds exactly one set bit (bit o selects output port o, all zero means no VC has been allocated), and the credit counter of the selected output port and `in_ovc` VC is non-zero.
- R2: A downstream VC with zero credits masks every request aimed at it, and that masked request does not stop another VC of the same input port from being granted in that cycle.
- R3: In each input port, at most one VC is granted per cycle. A round-robin pointer selects it, starting at VC 0 after reset. After a successful departure the pointer moves to the VC just after the winner.
- R4: In each output port, at most one input port is granted per cycle. A round-robin pointer starting at port 0 selects it and moves to the port after the winner. Distinct output ports grant in parallel in the same cycle.
- R5: In the same cycle as the request, `out_valid[o]` flags a departure, `out_src` slice o holds the one-hot source input port, and `out_vcid` slice o holds the winner's allocated output VC. `in_gnt` bit i*NVC+v marks the departing input VC.
- R6: A departure toward output port o, VC v lowers that credit counter by one at the next clock edge. A pulse on `cred_ret` bit o*NVC+v raises it by one.
- R7: Every credit counter resets to `DEPTH`. It keeps its value when a departure and a credit return hit it in the same cycle.
- R8: An input port whose first-level winner loses at the output stage sends no flit that cycle, and its first-level pointer is not advanced.
- R9: A credit return to a counter already at `DEPTH` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORT*NVC | Input VC i*NVC+v holds a flit |
| in_oport | input | NPORT*NVC*NPORT | One-hot allocated output port per input VC |
| in_ovc | input | NPORT*NVC*VCW | Allocated output VC per input VC |
| cred_ret | input | NPORT*NVC | Credit return pulse per downstream VC o*NVC+v |
| in_gnt | output | NPORT*NVC | Input VC whose flit departs this cycle |
| out_valid | output | NPORT | A flit leaves through output port o |
| out_src | output | NPORT*NPORT | One-hot source input port per output port |
| out_vcid | output | NPORT*VCW | New VC tag of the flit on output port o |
| cred_cnt | output | NPORT*NVC*CW | Credit count per downstream VC |

## Verification
A departure and a credit return can hit the same downstream VC counter in one cycle. A flit can also be arbitrated against a counter that the previous cycle's departure has just emptied. The bench drains a downstream VC to zero and confirms that its requests are masked while the sibling VC of the same port still goes out. It then returns one credit. In a later cycle it pairs a departure with a return on the same counter, and the count read at the next edge must be unchanged. That sum is judged against a count the bench keeps from the requirements alone.

// File: rtl/swa_pkg.sv
package swa_pkg;

  // Next position of a round-robin pointer: one past the winner, wrapping at n.
  function automatic int unsigned wrap_inc(int unsigned x, int unsigned n);
    return (x + 1 >= n) ? 0 : x + 1;
  endfunction

  // Credit arithmetic: take and give together cancel; never below 0 or above full.
  function automatic int unsigned credit_next(int unsigned c, logic take, logic give,
                                              int unsigned full);
    if (take && !give && c > 0)     return c - 1;
    if (give && !take && c < full)  return c + 1;
    return c;
  endfunction

endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win;
  logic          any;

  always_comb begin
    gnt = '0;
    win = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!any && req[idx]) begin
        any      = 1'b1;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ptr_q <= '0;
    else if (adv && any) ptr_q <= IW'(swa_pkg::wrap_inc(int'(win), N));
  end

endmodule

// File: rtl/swa_credit_ctr.sv
module swa_credit_ctr #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          give,
  output logic [CW-1:0] cnt,
  output logic          avail
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= CW'(DEPTH);
    else        cnt <= CW'(swa_pkg::credit_next(int'(cnt), take, give, DEPTH));
  end

  assign avail = (cnt != '0);

endmodule

// File: rtl/swa_switch_alloc.sv
module swa_switch_alloc #(
  parameter int NPORT = 5,
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  localparam int VCW  = (NVC > 1) ? $clog2(NVC) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT*NVC-1:0]       in_valid,
  input  logic [NPORT*NVC*NPORT-1:0] in_oport,
  input  logic [NPORT*NVC*VCW-1:0]   in_ovc,
  input  logic [NPORT*NVC-1:0]       cred_ret,
  output logic [NPORT*NVC-1:0]       in_gnt,
  output logic [NPORT-1:0]           out_valid,
  output logic [NPORT*NPORT-1:0]     out_src,
  output logic [NPORT*VCW-1:0]       out_vcid,
  output logic [NPORT*NVC*CW-1:0]    cred_cnt
);
  localparam int NIV = NPORT * NVC;

  // Named internal events, also observed by the bound checker
  logic [NIV-1:0]   has_cr;    // downstream VC o*NVC+v has a credit
  logic [NIV-1:0]   elig;      // input VC passes the credit mask
  logic [NIV-1:0]   s1_gnt;    // first-level winners
  logic [NPORT-1:0] won;       // input port's winner won its output
  logic [NIV-1:0]   send_ov;   // departure toward downstream VC o*NVC+v

  logic [NPORT-1:0] s1_oport [NPORT];
  logic [VCW-1:0]   s1_ovc   [NPORT];
  logic [NPORT-1:0] s2_req   [NPORT];
  logic [NPORT-1:0] s2_gnt   [NPORT];

  // Request masking by downstream credit
  always_comb begin
    for (int iv = 0; iv < NIV; iv++) begin
      logic [NPORT-1:0] op;
      logic [VCW-1:0]   ov;
      logic             ok;
      op = in_oport[iv*NPORT +: NPORT];
      ov = in_ovc[iv*VCW +: VCW];
      ok = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        if (op[o] && int'(ov) < NVC && has_cr[o*NVC + int'(ov)]) ok = 1'b1;
      end
      elig[iv] = in_valid[iv] && $onehot(op) && ok;
    end
  end

  // First level: one VC per input port
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    swa_rr_arb #(.N(NVC)) u_vc_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (elig[i*NVC +: NVC]),
      .adv  (won[i]),
      .gnt  (s1_gnt[i*NVC +: NVC])
    );
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      s1_oport[i] = '0;
      s1_ovc[i]   = '0;
      for (int v = 0; v < NVC; v++) begin
        if (s1_gnt[i*NVC+v]) begin
          s1_oport[i] = in_oport[(i*NVC+v)*NPORT +: NPORT];
          s1_ovc[i]   = in_ovc[(i*NVC+v)*VCW +: VCW];
        end
      end
    end
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        s2_req[o][i] = s1_oport[i][o];
  end

  // Second level: one input port per output port
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    swa_rr_arb #(.N(NPORT)) u_port_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (s2_req[o]),
      .adv  (1'b1),
      .gnt  (s2_gnt[o])
    );
  end

  always_comb begin
    won = '0;
    for (int o = 0; o < NPORT; o++) begin
      logic [VCW-1:0] tag;
      tag = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (s2_gnt[o][i]) begin
          won[i] = 1'b1;
          tag    = s1_ovc[i];
        end
      end
      out_valid[o]                = |s2_gnt[o];
      out_src[o*NPORT +: NPORT]   = s2_gnt[o];
      out_vcid[o*VCW +: VCW]      = tag;
      for (int v = 0; v < NVC; v++)
        send_ov[o*NVC+v] = out_valid[o] && (int'(tag) == v);
    end
    for (int i = 0; i < NPORT; i++)
      in_gnt[i*NVC +: NVC] = won[i] ? s1_gnt[i*NVC +: NVC] : '0;
  end

  // Per-downstream-VC credit counters
  for (genvar k = 0; k < NIV; k++) begin : g_cr
    swa_credit_ctr #(.DEPTH(DEPTH), .CW(CW)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .take (send_ov[k]),
      .give (cred_ret[k]),
      .cnt  (cred_cnt[k*CW +: CW]),
      .avail(has_cr[k])
    );
  end

endmodule

// File: rtl/swa_switch_alloc_chk.sv
module swa_switch_alloc_chk #(
  parameter int NPORT = 5,
  parameter int NVC   = 2,
  parameter int DEPTH = 4,
  parameter int VCW   = 1,
  parameter int CW    = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NPORT*NVC-1:0]     in_gnt,
  input logic [NPORT-1:0]         out_valid,
  input logic [NPORT*NPORT-1:0]   out_src,
  input logic [NPORT*NVC-1:0]     cred_ret,
  input logic [NPORT*NVC*CW-1:0]  cred_cnt,
  input logic [NPORT*NVC-1:0]     send_ov
);
  // R5: number of departing input VCs equals number of busy output ports
  a_r5_grant_balance: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_gnt) == $countones(out_valid));

  for (genvar i = 0; i < NPORT; i++) begin : g_pi
    a_r3_one_vc_per_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_gnt[i*NVC +: NVC]));
    a_r4_one_src_per_out: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] |-> $onehot(out_src[i*NPORT +: NPORT]));
  end

  for (genvar k = 0; k < NPORT*NVC; k++) begin : g_k
    a_r2_no_send_without_credit: assert property (@(posedge clk) disable iff (!rst_n)
      send_ov[k] |-> (cred_cnt[k*CW +: CW] != '0));
    a_r6_take_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (send_ov[k] && !cred_ret[k]) |=> (cred_cnt[k*CW +: CW] == $past(cred_cnt[k*CW +: CW]) - 1'b1));
    a_r7_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (send_ov[k] && cred_ret[k]) |=> $stable(cred_cnt[k*CW +: CW]));
    a_r9_never_above_depth: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cred_cnt[k*CW +: CW]) <= DEPTH);
  end
endmodule

bind swa_switch_alloc swa_switch_alloc_chk #(
  .NPORT(NPORT), .NVC(NVC), .DEPTH(DEPTH), .VCW(VCW), .CW(CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_gnt   (in_gnt),
  .out_valid(out_valid),
  .out_src  (out_src),
  .cred_ret (cred_ret),
  .cred_cnt (cred_cnt),
  .send_ov  (send_ov)
);

// File: tb/swa_switch_alloc_tb.sv
module swa_switch_alloc_tb;
  localparam int NP  = 5;
  localparam int NV  = 2;
  localparam int DP  = 4;
  localparam int VW  = 1;
  localparam int CWB = 3;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NP*NV-1:0]     in_valid;
  logic [NP*NV*NP-1:0]  in_oport;
  logic [NP*NV*VW-1:0]  in_ovc;
  logic [NP*NV-1:0]     cred_ret;
  logic [NP*NV-1:0]     in_gnt;
  logic [NP-1:0]        out_valid;
  logic [NP*NP-1:0]     out_src;
  logic [NP*VW-1:0]     out_vcid;
  logic [NP*NV*CWB-1:0] cred_cnt;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  swa_switch_alloc #(.NPORT(NP), .NVC(NV), .DEPTH(DP)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_oport(in_oport),
    .in_ovc(in_ovc), .cred_ret(cred_ret), .in_gnt(in_gnt), .out_valid(out_valid),
    .out_src(out_src), .out_vcid(out_vcid), .cred_cnt(cred_cnt)
  );

  function automatic int src(int o);   return int'(out_src[o*NP +: NP]); endfunction
  function automatic int vtag(int o);  return int'(out_vcid[o*VW +: VW]); endfunction
  function automatic int ig(int i);    return int'(in_gnt[i*NV +: NV]); endfunction
  function automatic int cred(int o, int v); return int'(cred_cnt[(o*NV+v)*CWB +: CWB]); endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_oport = '0; in_ovc = '0; cred_ret = '0;
  endtask

  task automatic set_req(int i, int v, int o, int ovc);
    in_valid[i*NV+v]             = 1'b1;
    in_oport[(i*NV+v)*NP +: NP]  = NP'(1 << o);
    in_ovc[(i*NV+v)*VW +: VW]    = VW'(ovc);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clear_in();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    #2;
    for (int o = 0; o < NP; o++)
      for (int v = 0; v < NV; v++) chk("R7 reset credit", cred(o, v), DP);
    chk("R5 idle no departures", int'(out_valid), 0);
  endtask

  task automatic t_single();
    do_reset();
    set_req(4, 0, 1, 0);
    in_oport[(4*NV+0)*NP +: NP] = '0;      // no output allocated
    set_req(0, 0, 2, 1);
    #2;
    chk("R5 out_valid", int'(out_valid), 5'b00100);
    chk("R5 source port", src(2), 5'b00001);
    chk("R5 new VC tag", vtag(2), 1);
    chk("R5 in_gnt port0", ig(0), 2'b01);
    chk("R1 unallocated VC idle", ig(4), 0);
    @(negedge clk);
    clear_in();
    chk("R6 credit taken", cred(2, 1), DP - 1);
    chk("R6 other VC untouched", cred(2, 0), DP);
  endtask

  task automatic t_vc_rotation();
    do_reset();
    set_req(1, 0, 3, 0);
    set_req(1, 1, 4, 1);
    #2;
    chk("R3 first pick vc0", ig(1), 2'b01);
    chk("R3 one flit per port", int'(out_valid), 5'b01000);
    @(negedge clk); #2;
    chk("R3 rotate to vc1", ig(1), 2'b10);
    chk("R3 vc1 output", int'(out_valid), 5'b10000);
    chk("R5 tag vc1", vtag(4), 1);
    @(negedge clk); #2;
    chk("R3 wrap to vc0", ig(1), 2'b01);
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_out_contention();
    do_reset();
    set_req(0, 0, 4, 0); set_req(1, 0, 4, 0); set_req(2, 0, 4, 0);
    #2;
    chk("R4 first winner port0", src(4), 5'b00001);
    chk("R4 loser port1 idle", ig(1), 0);
    chk("R4 loser port2 idle", ig(2), 0);
    @(negedge clk); #2;
    chk("R4 rotate port1", src(4), 5'b00010);
    @(negedge clk); #2;
    chk("R4 rotate port2", src(4), 5'b00100);
    @(negedge clk);
    clear_in();
    chk("R6 three departures", cred(4, 0), DP - 3);
    // all outputs at once
    do_reset();
    for (int i = 0; i < NP; i++) set_req(i, 1, (i + 1) % NP, i % 2);
    #2;
    chk("R4 parallel outputs", int'(out_valid), 5'b11111);
    for (int i = 0; i < NP; i++) begin
      chk("R4 parallel source", src((i + 1) % NP), 1 << i);
      chk("R5 parallel tag", vtag((i + 1) % NP), i % 2);
    end
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_loser_hold();
    do_reset();
    set_req(1, 0, 1, 0);
    #2;
    chk("R4 out1 from port1", src(1), 5'b00010);
    @(negedge clk);
    clear_in();
    set_req(0, 0, 1, 0); set_req(0, 1, 2, 0); set_req(2, 0, 1, 1);
    #2;
    chk("R8 port2 wins out1", src(1), 5'b00100);
    chk("R8 loser port0 sends nothing", ig(0), 0);
    chk("R8 out2 idle", int'(out_valid[2]), 0);
    @(negedge clk);
    clear_in();
    set_req(0, 0, 1, 0); set_req(0, 1, 2, 0);
    #2;
    chk("R8 pointer kept at vc0", ig(0), 2'b01);
    chk("R8 out1 from port0", src(1), 5'b00001);
    chk("R8 out2 still idle", int'(out_valid[2]), 0);
    @(negedge clk);
    clear_in();
  endtask

  task automatic t_credit_mask_and_return();
    do_reset();
    set_req(3, 0, 0, 0);
    for (int c = 0; c < DP; c++) begin
      #2;
      chk("R2 send while credit", int'(out_valid[0]), 1);
      @(negedge clk);
    end
    #2;
    chk("R2 drained counter", cred(0, 0), 0);
    chk("R2 masked, no departure", int'(out_valid[0]), 0);
    chk("R2 masked, no in_gnt", ig(3), 0);
    @(negedge clk);
    set_req(3, 1, 0, 1);
    #2;
    chk("R2 sibling VC passes", ig(3), 2'b10);
    chk("R2 sibling tag", vtag(0), 1);
    @(negedge clk);
    clear_in();
    chk("R6 sibling credit", cred(0, 1), DP - 1);
    cred_ret[0] = 1'b1;
    @(negedge clk);
    cred_ret = '0;
    chk("R6 return adds one", cred(0, 0), 1);
    set_req(3, 0, 0, 0);
    cred_ret[0] = 1'b1;
    #2;
    chk("R7 send with one credit", int'(out_valid[0]), 1);
    @(negedge clk);
    cred_ret = '0;
    chk("R7 take and give hold", cred(0, 0), 1);
    #2;
    @(negedge clk);
    clear_in();
    chk("R6 last credit used", cred(0, 0), 0);
  endtask

  task automatic t_full_return();
    do_reset();
    cred_ret[2*NV+0] = 1'b1;
    @(negedge clk);
    cred_ret = '0;
    chk("R9 return at full ignored", cred(2, 0), DP);
  endtask

  initial begin
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_single();
    t_vc_rotation();
    t_out_contention();
    t_loser_hold();
    t_credit_mask_and_return();
    t_full_return();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule